// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block supervises a processor by counting ticks of a 1/16-second time base and firing when software has not restarted it within a programmed window. The window is set through one 8-bit configuration register that holds a 5-bit multiplier and a 2-bit resolution code. The timeout is the product of the two. A steering bit in the same register decides what a timeout does. It either holds an active-low interrupt request until software releases it, or it drives an active-low reset pulse that lasts a set number of ticks.

Software restarts the timer by rewriting the register. External logic can also restart it by toggling the watchdog input pin, which is synchronized before its edges are detected. A watchdog flag records every timeout and is cleared by a read strobe on the flags register. When the reset pulse ends, the register is cleared and a one-cycle strobe tells the neighbouring clock logic to clear its frequency-test bit. A single clear input stands in for power-down: it zeroes the register and stops the timer.

Top module: `prog_watchdog`

## Requirements
- R1: After reset, cfg_o is 00h, wdf_o is 0, irq_no is 1, rst_no is 1 and ftest_clr_o is 0.
- R2: A write strobe loads wdata_i into the register, which cfg_o shows from the next cycle. The field layout is bit 7 = steering, bits 6..2 = multiplier, bits 1..0 = resolution code.
- R3: The timeout is the multiplier times a resolution unit, where codes 00, 01, 10 and 11 give 1, 4, 16 and 64 ticks. The flag sets in the cycle after the tick that completes that many ticks since the last restart. The largest setting, 7Fh, takes 1984 ticks.
- R4: A multiplier of zero disables the timer, and this includes writing all zeros. No timeout then occurs, whatever the resolution code is.
- R5: Any write to the register restarts the tick count from zero.
- R6: A rising or a falling edge on wdi_i restarts the tick count. The edge takes effect within three clock cycles.
- R7: With steering 0, a timeout drives irq_no low. It stays low until a write of 00h, or until the clear input.
- R8: A timeout sets wdf_o, and a flags read strobe clears it. If a timeout and a read fall in the same cycle, the flag is set.
- R9: With steering 1, a timeout drives rst_no low for RST_TICKS further ticks. In the cycle rst_no returns high, cfg_o is 00h and ftest_clr_o is high for exactly one cycle. A timeout during the pulse does not restart it.
- R10: The clear input zeroes the register and resets the tick count. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse of the 1/16 s time base |
| wr_i | input | 1 | Configuration register write strobe |
| wdata_i | input | 8 | Configuration write data |
| wdi_i | input | 1 | Asynchronous watchdog input pin |
| flag_rd_i | input | 1 | Flags register read strobe |
| pwr_clr_i | input | 1 | Power-down clear |
| cfg_o | output | 8 | Current configuration register |
| wdf_o | output | 1 | Watchdog flag |
| irq_no | output | 1 | Active-low interrupt request |
| rst_no | output | 1 | Active-low reset pulse |
| ftest_clr_o | output | 1 | One-cycle strobe to clear the frequency-test bit |

## Verification
A tick counter that holds a wrong value, or that misses a restart, shows up at wdf_o as a timeout one or more ticks early or late. For that reason each resolution code and the largest setting are checked at the exact tick on which the flag must rise, and again one tick before it. A wrong steering decision or a pulse length that is off by one shows on irq_no and rst_no in the cycle after the expiring tick, or at the tick on which the pulse should end. A register that is not cleared at the end of the pulse shows on cfg_o in the same cycle that rst_no rises.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int unsigned MULT_W = 5;
  localparam int unsigned RES_W  = 2;
  localparam int unsigned CFG_W  = 1 + MULT_W + RES_W;
  // each resolution step is 4x the previous one
  localparam int unsigned MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int unsigned CNT_W  = MULT_W + MAX_SHIFT;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdt_cfg_t;

  function automatic logic [CNT_W-1:0] limit_of(input logic [MULT_W-1:0] m,
                                                input logic [RES_W-1:0] r);
    return CNT_W'(m) << (2 * r);
  endfunction
endpackage

// File: rtl/wdt_sync.sv
`timescale 1ns/1ps
module wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= din_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
module wdt_timer
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              stop_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             enabled;

  assign limit    = limit_of(mult_i, res_i);
  assign enabled  = (mult_i != '0);
  assign expire_o = tick_i && enabled && !kick_i && !stop_i &&
                    (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (stop_i || kick_i || !enabled) cnt_q <= '0;
    else if (tick_i)                      cnt_q <= expire_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse #(
  parameter int unsigned LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;
  logic          active_q;

  assign done_o   = active_q && tick_i && (left_q == LW'(1));
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        left_q   <= LW'(LEN);
      end
    end else if (tick_i) begin
      if (done_o) begin
        active_q <= 1'b0;
        left_q   <= '0;
      end else begin
        left_q <= left_q - LW'(1);
      end
    end
  end
endmodule

// File: rtl/prog_watchdog.sv
`timescale 1ns/1ps
module prog_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned RST_TICKS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             wdi_i,
  input  logic             flag_rd_i,
  input  logic             pwr_clr_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             wdf_o,
  output logic             irq_no,
  output logic             rst_no,
  output logic             ftest_clr_o
);
  wdt_cfg_t cfg_q;
  logic     wdi_edge, kick, expire;
  logic     pulse_active, pulse_done;
  logic     wdf_q, irq_q, ftc_q;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (wdi_i),
    .edge_o (wdi_edge)
  );

  assign kick = wr_i | wdi_edge;

  wdt_timer u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .kick_i   (kick),
    .stop_i   (pwr_clr_i),
    .mult_i   (cfg_q.mult),
    .res_i    (cfg_q.res),
    .expire_o (expire)
  );

  wdt_pulse #(.LEN(RST_TICKS)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .start_i  (expire && cfg_q.steer),
    .active_o (pulse_active),
    .done_o   (pulse_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      wdf_q <= 1'b0;
      irq_q <= 1'b0;
      ftc_q <= 1'b0;
    end else begin
      if (pwr_clr_i || pulse_done) cfg_q <= '0;
      else if (wr_i)               cfg_q <= wdt_cfg_t'(wdata_i);

      if (expire)         wdf_q <= 1'b1;
      else if (flag_rd_i) wdf_q <= 1'b0;

      if (pwr_clr_i || (wr_i && wdata_i == '0)) irq_q <= 1'b0;
      else if (expire && !cfg_q.steer)          irq_q <= 1'b1;

      ftc_q <= pulse_done;
    end
  end

  assign cfg_o       = cfg_q;
  assign wdf_o       = wdf_q;
  assign irq_no      = ~irq_q;
  assign rst_no      = ~pulse_active;
  assign ftest_clr_o = ftc_q;
endmodule

// File: rtl/prog_watchdog_chk.sv
`timescale 1ns/1ps
module prog_watchdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic       wdi_i,
  input logic       flag_rd_i,
  input logic       pwr_clr_i,
  input logic [7:0] cfg_o,
  input logic       wdf_o,
  input logic       irq_no,
  input logic       rst_no,
  input logic       ftest_clr_o
);
  // R2
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pwr_clr_i && rst_no) |=> (cfg_o == $past(wdata_i)));

  // R4
  flag_needs_mult_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdf_o) |-> ($past(cfg_o[6:2]) != 5'd0));

  // R7
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past((wr_i && wdata_i == 8'h00) || pwr_clr_i));

  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdf_o) |-> $past(flag_rd_i));

  // R9
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (cfg_o == 8'h00 && ftest_clr_o));

  // R9
  ftc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftest_clr_o |=> !ftest_clr_o);

  // R10
  pwr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_clr_i |=> (cfg_o == 8'h00));
endmodule

bind prog_watchdog prog_watchdog_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .wdi_i       (wdi_i),
  .flag_rd_i   (flag_rd_i),
  .pwr_clr_i   (pwr_clr_i),
  .cfg_o       (cfg_o),
  .wdf_o       (wdf_o),
  .irq_no      (irq_no),
  .rst_no      (rst_no),
  .ftest_clr_o (ftest_clr_o)
);

// File: tb/prog_watchdog_test.sv
`timescale 1ns/1ps
module prog_watchdog_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, wr_i = 1'b0, wdi_i = 1'b0, flag_rd_i = 1'b0, pwr_clr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] cfg_o;
  logic       wdf_o, irq_no, rst_no, ftest_clr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    string      tag;
    logic       wdf;
    logic       irq_n;
    logic       rst_n;
    logic [7:0] cfg;
    logic       ftc;
  } exp_t;
  exp_t q[$];

  prog_watchdog #(.RST_TICKS(2)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .wdi_i(wdi_i), .flag_rd_i(flag_rd_i),
    .pwr_clr_i(pwr_clr_i), .cfg_o(cfg_o), .wdf_o(wdf_o),
    .irq_no(irq_no), .rst_no(rst_no), .ftest_clr_o(ftest_clr_o)
  );

  always #2 clk_i = ~clk_i;

  // monitor: compare queued expectations with registered outputs
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (wdf_o !== e.wdf || irq_no !== e.irq_n || rst_no !== e.rst_n ||
          cfg_o !== e.cfg || ftest_clr_o !== e.ftc) begin
        bad++;
        $display("FAIL %s: got wdf=%b irq_n=%b rst_n=%b cfg=%h ftc=%b exp wdf=%b irq_n=%b rst_n=%b cfg=%h ftc=%b",
                 e.tag, wdf_o, irq_no, rst_no, cfg_o, ftest_clr_o,
                 e.wdf, e.irq_n, e.rst_n, e.cfg, e.ftc);
      end
    end
  end

  task automatic expect_out(input string tag, input logic wdf, input logic irq_n,
                            input logic rst_n, input logic [7:0] cfg, input logic ftc);
    exp_t e;
    e.tag = tag; e.wdf = wdf; e.irq_n = irq_n; e.rst_n = rst_n; e.cfg = cfg; e.ftc = ftc;
    q.push_back(e);
  endtask

  task automatic step(input logic t, input logic w, input logic [7:0] d,
                      input logic rd, input logic c);
    @(negedge clk_i);
    tick_i = t; wr_i = w; wdata_i = d; flag_rd_i = rd; pwr_clr_i = c;
    @(posedge clk_i);
    #1;
    tick_i = 0; wr_i = 0; flag_rd_i = 0; pwr_clr_i = 0;
  endtask

  task automatic tk();            step(1, 0, 8'h00, 0, 0); endtask
  task automatic idle();          step(0, 0, 8'h00, 0, 0); endtask
  task automatic wr(input logic [7:0] d); step(0, 1, d, 0, 0); endtask
  task automatic clean();         step(0, 1, 8'h00, 1, 0); endtask
  task automatic set_wdi(input logic v); @(negedge clk_i); wdi_i = v; endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    expect_out("R1 reset state", 0, 1, 1, 8'h00, 0);

    wr(8'h08);
    expect_out("R2 write loads cfg", 0, 1, 1, 8'h08, 0);
    tk();
    expect_out("R3 code00 one tick early", 0, 1, 1, 8'h08, 0);
    tk();
    expect_out("R7 timeout irq low", 1, 0, 1, 8'h08, 0);
    step(0, 0, 8'h00, 1, 0);
    expect_out("R8 read clears flag", 0, 0, 1, 8'h08, 0);
    wr(8'h00);
    expect_out("R7 write 00h releases irq", 0, 1, 1, 8'h00, 0);
    repeat (5) tk();
    expect_out("R4 all zeros disabled", 0, 1, 1, 8'h00, 0);

    wr(8'h05);
    repeat (3) tk();
    expect_out("R3 code01 three ticks", 0, 1, 1, 8'h05, 0);
    tk();
    expect_out("R3 code01 four ticks", 1, 0, 1, 8'h05, 0);
    clean();
    expect_out("R7 clean", 0, 1, 1, 8'h00, 0);

    wr(8'h08); tk(); wr(8'h08); tk();
    expect_out("R5 rewrite restarts", 0, 1, 1, 8'h08, 0);
    tk();
    expect_out("R5 expiry after restart", 1, 0, 1, 8'h08, 0);
    clean();

    wr(8'h08); tk(); set_wdi(1); repeat (3) idle(); tk();
    expect_out("R6 rising edge restarts", 0, 1, 1, 8'h08, 0);
    tk();
    expect_out("R6 expiry after rising", 1, 0, 1, 8'h08, 0);
    clean();
    wr(8'h08); tk(); set_wdi(0); repeat (3) idle(); tk();
    expect_out("R6 falling edge restarts", 0, 1, 1, 8'h08, 0);
    tk();
    expect_out("R6 expiry after falling", 1, 0, 1, 8'h08, 0);
    clean();

    wr(8'h88); tk();
    expect_out("R9 before timeout", 0, 1, 1, 8'h88, 0);
    tk();
    expect_out("R9 pulse starts", 1, 1, 0, 8'h88, 0);
    tk();
    expect_out("R9 pulse held", 1, 1, 0, 8'h88, 0);
    tk();
    expect_out("R9 pulse end clears cfg", 1, 1, 1, 8'h00, 1);
    idle();
    expect_out("R9 ftc one cycle", 1, 1, 1, 8'h00, 0);
    step(0, 0, 8'h00, 1, 0);
    expect_out("R8 read after pulse", 0, 1, 1, 8'h00, 0);

    wr(8'h03);
    repeat (70) tk();
    expect_out("R4 zero multiplier disabled", 0, 1, 1, 8'h03, 0);
    wr(8'h00);

    wr(8'h08); tk(); step(0, 0, 8'h00, 0, 1);
    expect_out("R10 clear zeroes cfg", 0, 1, 1, 8'h00, 0);
    repeat (3) tk();
    expect_out("R10 timer stopped", 0, 1, 1, 8'h00, 0);
    step(0, 1, 8'h08, 0, 1);
    expect_out("R10 clear beats write", 0, 1, 1, 8'h00, 0);

    wr(8'h08); tk(); step(1, 0, 8'h00, 1, 0);
    expect_out("R8 set wins over read", 1, 0, 1, 8'h08, 0);
    clean();

    wr(8'h7F);
    for (int i = 0; i < 1983; i++) tk();
    expect_out("R3 max one tick early", 0, 1, 1, 8'h7F, 0);
    tk();
    expect_out("R3 max 1984 ticks", 1, 0, 1, 8'h7F, 0);
    clean();
    expect_out("R7 final clean", 0, 1, 1, 8'h00, 0);

    repeat (2) @(negedge clk_i);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule